// File: doc/BRIEF.md
# DMA Line-Chunking Request Sequencer

This block takes one DMA transfer at a time from an upstream requester, described by a byte address, a byte length and, for a write, the payload bytes. It splits the transfer into line-sized pieces and sends each piece downstream as a load or store message over a valid/ready channel. It waits for the reply to each piece before it issues the next one. Writes are acknowledged by the reply. Reads return a whole line, and the block copies the wanted bytes out of it. When the last piece has returned, the block raises a one-cycle completion toward the requester.

The first piece runs from the request address to the end of its line at most. Every later piece starts on a line boundary. A request that arrives while a transfer is in flight is refused, not queued. The refused requester is told to try again by a one-cycle retry strobe once the block is free. A drain query reports at once if nothing is outstanding. Otherwise a drained pulse follows when the active transfer ends.

Top module: `dmaseq_top`

## Requirements
- R1: Only one transfer is active at a time. A request with `req_valid` high while idle is accepted in that cycle (`req_accept`=1). While busy it is refused (`req_refuse`=1, `req_accept`=0), is not stored, and causes no downstream message.
- R2: A refusal sets a pending-retry flag. In the cycle after the final reply of the active transfer, `retry_pulse` is high for exactly one cycle and the flag clears. With no refusal, `retry_pulse` stays low.
- R3: The first piece has `ds_addr` equal to the request address. Its `ds_len` is the whole length when (address mod LINE_BYTES) plus length is at most LINE_BYTES, and LINE_BYTES minus that offset otherwise. An accepted request presents its first piece in the next cycle.
- R4: Each later piece starts at the request address plus the bytes already completed. That address is line-aligned, and its length is the smaller of the remaining bytes and LINE_BYTES.
- R5: `ds_store` is 1 for a write transfer and 0 for a read. `ds_line_addr` equals `ds_addr` with its low log2(LINE_BYTES) bits cleared.
- R6: A piece is counted as issued only in a cycle with `ds_valid` and `ds_ready` both high. While `ready` is low, `ds_valid`, `ds_addr` and `ds_len` hold steady. No further piece is issued until `ds_resp_valid` returns for the current one. A transfer of offset o and length n uses ceil((o+n)/LINE_BYTES) pieces.
- R7: The block is idle in the cycle in which the completion is shown, so a request presented in that cycle is accepted.
- R8: Write bytes travel on `ds_wdata` in the byte lanes of their line positions: lane (ds_addr mod LINE_BYTES)+k carries payload byte (completed+k). For reads, returned line bytes are taken from lane = address offset for the first piece and from lane 0 for later pieces. `rsp_rdata` byte i then equals the memory byte at request address + i.
- R9: If `req_need_rsp` was 1, `rsp_valid` is high for exactly one cycle, the cycle after the final reply. If it was 0, no completion is shown.
- R10: `drain_idle` is high in any cycle with `drain_query` high while no transfer is active. A query made while busy gives `drain_idle`=0, and `drain_done` then pulses in the cycle after the final reply.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| req_valid | input | 1 | Upstream request present |
| req_write | input | 1 | 1 = write transfer, 0 = read |
| req_need_rsp | input | 1 | 1 = a completion must be returned |
| req_addr | input | ADDR_W | Start byte address |
| req_len | input | LEN_W | Length in bytes, 1..MAX_LEN |
| req_wdata | input | MAX_LEN*8 | Write payload, byte i in bits [8i+7:8i] |
| req_accept | output | 1 | Request taken this cycle |
| req_refuse | output | 1 | Request refused, buffer full |
| retry_pulse | output | 1 | One-cycle strobe telling a refused requester to retry |
| rsp_valid | output | 1 | One-cycle completion |
| rsp_write | output | 1 | Kind of the completed transfer |
| rsp_rdata | output | MAX_LEN*8 | Read payload, byte i in bits [8i+7:8i] |
| ds_valid | output | 1 | Downstream piece message valid |
| ds_ready | input | 1 | Downstream accepts the message |
| ds_store | output | 1 | 1 = store, 0 = load |
| ds_addr | output | ADDR_W | Byte address of the piece |
| ds_line_addr | output | ADDR_W | Line address of the piece |
| ds_len | output | CLEN_W | Piece length in bytes |
| ds_wdata | output | LINE_BYTES*8 | Store bytes in line lanes |
| ds_resp_valid | input | 1 | Reply for the outstanding piece (ack or data) |
| ds_resp_data | input | LINE_BYTES*8 | Returned line for loads |
| drain_query | input | 1 | Drain status request |
| drain_idle | output | 1 | Nothing outstanding at query time |
| drain_done | output | 1 | One-cycle pulse when a pending drain completes |

## Verification
The assertions check the channel rules every cycle: a stalled message holds steady, every piece fits inside one line, later pieces are aligned, the first piece starts at the stored address, an accepted request issues at once, and the completion, retry and drained strobes last a single cycle and are raised only as a transfer ends. Other behaviours depend on whole-transfer arithmetic, and only the bench scenarios can show them. These are the exact piece lengths and counts, the bytes that land in memory from the lane placement, and the read payload assembled from offset and zero-based extractions. Also scenario-only are the refused request that leaves no trace, the immediate acceptance of a retried request, and the silent completion of a request that asked for no reply.

// File: rtl/dmaseq_pkg.sv
package dmaseq_pkg;
  typedef enum logic [1:0] {
    SQ_IDLE  = 2'd0,
    SQ_ISSUE = 2'd1,
    SQ_WAIT  = 2'd2
  } sq_state_e;
endpackage

// File: rtl/dmaseq_rst_sync.sv
module dmaseq_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sn
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= 2'b00;
    end else begin
      sync_q <= {sync_q[0], 1'b1};
    end
  end

  assign rst_sn = sync_q[1];
endmodule

// File: rtl/dmaseq_chunk_calc.sv
// Computes the position and size of the next piece from the transfer
// start, its total length and the bytes already completed.
module dmaseq_chunk_calc #(
  parameter int ADDR_W     = 12,
  parameter int LINE_BYTES = 8,
  parameter int MAX_LEN    = 24,
  localparam int OFF_W     = $clog2(LINE_BYTES),
  localparam int LEN_W     = $clog2(MAX_LEN + 1),
  localparam int CLEN_W    = $clog2(LINE_BYTES + 1)
) (
  input  logic [ADDR_W-1:0] start_addr,
  input  logic [LEN_W-1:0]  total_len,
  input  logic [LEN_W-1:0]  done_len,
  output logic [ADDR_W-1:0] chunk_addr,
  output logic [OFF_W-1:0]  chunk_off,
  output logic [CLEN_W-1:0] chunk_len,
  output logic [LEN_W-1:0]  next_done
);
  localparam int CW = ((LEN_W > CLEN_W) ? LEN_W : CLEN_W) + 1;

  logic [CW-1:0] remain;
  logic [CW-1:0] room;

  always_comb begin
    chunk_addr = start_addr + ADDR_W'(done_len);
    chunk_off  = chunk_addr[OFF_W-1:0];
    remain     = CW'(total_len) - CW'(done_len);
    room       = CW'(LINE_BYTES) - CW'(chunk_off);
    chunk_len  = CLEN_W'((remain < room) ? remain : room);
    next_done  = LEN_W'(CW'(done_len) + CW'(chunk_len));
  end
endmodule

// File: rtl/dmaseq_wr_scatter.sv
// Places the payload bytes of the current piece into their line lanes.
module dmaseq_wr_scatter #(
  parameter int LINE_BYTES = 8,
  parameter int MAX_LEN    = 24,
  localparam int OFF_W     = $clog2(LINE_BYTES),
  localparam int LEN_W     = $clog2(MAX_LEN + 1),
  localparam int CLEN_W    = $clog2(LINE_BYTES + 1),
  localparam int IDX_W     = $clog2(MAX_LEN)
) (
  input  logic [MAX_LEN*8-1:0]    payload,
  input  logic [LEN_W-1:0]        done_len,
  input  logic [OFF_W-1:0]        chunk_off,
  input  logic [CLEN_W-1:0]       chunk_len,
  output logic [LINE_BYTES*8-1:0] line_data
);
  logic [7:0] pay_b [MAX_LEN];

  for (genvar j = 0; j < MAX_LEN; j++) begin : g_unpack
    assign pay_b[j] = payload[j*8 +: 8];
  end

  for (genvar k = 0; k < LINE_BYTES; k++) begin : g_lane
    int         src;
    logic       hit;
    logic [7:0] lane_b;

    always_comb begin
      src = int'(done_len) + k - int'(chunk_off);
      hit = (k >= int'(chunk_off)) &&
            (k < int'(chunk_off) + int'(chunk_len)) &&
            (src >= 0) && (src < MAX_LEN);
      lane_b = 8'h00;
      if (hit) begin
        lane_b = pay_b[IDX_W'(src)];
      end
    end

    assign line_data[k*8 +: 8] = lane_b;
  end
endmodule

// File: rtl/dmaseq_rd_gather.sv
// Copies the wanted bytes of a returned line into the read payload buffer.
module dmaseq_rd_gather #(
  parameter int LINE_BYTES = 8,
  parameter int MAX_LEN    = 24,
  localparam int OFF_W     = $clog2(LINE_BYTES),
  localparam int LEN_W     = $clog2(MAX_LEN + 1),
  localparam int CLEN_W    = $clog2(LINE_BYTES + 1)
) (
  input  logic                    clk,
  input  logic                    cap_en,
  input  logic [LEN_W-1:0]        done_len,
  input  logic [OFF_W-1:0]        chunk_off,
  input  logic [CLEN_W-1:0]       chunk_len,
  input  logic [LINE_BYTES*8-1:0] line_data,
  output logic [MAX_LEN*8-1:0]    gathered
);
  logic [7:0] line_b [LINE_BYTES];

  for (genvar k = 0; k < LINE_BYTES; k++) begin : g_unpack
    assign line_b[k] = line_data[k*8 +: 8];
  end

  for (genvar j = 0; j < MAX_LEN; j++) begin : g_byte
    logic             hit;
    logic [OFF_W-1:0] lane;
    logic [7:0]       slot_q;

    always_comb begin
      hit  = (j >= int'(done_len)) &&
             (j < int'(done_len) + int'(chunk_len));
      lane = OFF_W'(int'(chunk_off) + j - int'(done_len));
    end

    always_ff @(posedge clk) begin
      if (cap_en && hit) begin
        slot_q <= line_b[lane];
      end
    end

    assign gathered[j*8 +: 8] = slot_q;
  end
endmodule

// File: rtl/dmaseq_top.sv
module dmaseq_top #(
  parameter int ADDR_W     = 12,
  parameter int LINE_BYTES = 8,
  parameter int MAX_LEN    = 24,
  localparam int OFF_W     = $clog2(LINE_BYTES),
  localparam int LEN_W     = $clog2(MAX_LEN + 1),
  localparam int CLEN_W    = $clog2(LINE_BYTES + 1)
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    req_valid,
  input  logic                    req_write,
  input  logic                    req_need_rsp,
  input  logic [ADDR_W-1:0]       req_addr,
  input  logic [LEN_W-1:0]        req_len,
  input  logic [MAX_LEN*8-1:0]    req_wdata,
  output logic                    req_accept,
  output logic                    req_refuse,
  output logic                    retry_pulse,
  output logic                    rsp_valid,
  output logic                    rsp_write,
  output logic [MAX_LEN*8-1:0]    rsp_rdata,
  output logic                    ds_valid,
  input  logic                    ds_ready,
  output logic                    ds_store,
  output logic [ADDR_W-1:0]       ds_addr,
  output logic [ADDR_W-1:0]       ds_line_addr,
  output logic [CLEN_W-1:0]       ds_len,
  output logic [LINE_BYTES*8-1:0] ds_wdata,
  input  logic                    ds_resp_valid,
  input  logic [LINE_BYTES*8-1:0] ds_resp_data,
  input  logic                    drain_query,
  output logic                    drain_idle,
  output logic                    drain_done
);
  import dmaseq_pkg::*;

  logic rst_sn;

  sq_state_e         state_q, state_d;
  logic [ADDR_W-1:0] start_q, start_d;
  logic [LEN_W-1:0]  total_q, total_d;
  logic [LEN_W-1:0]  done_q, done_d;
  logic [LEN_W-1:0]  issued_q, issued_d;
  logic              write_q, write_d;
  logic              need_q, need_d;
  logic              retry_pend_q, retry_pend_d;
  logic              drain_pend_q, drain_pend_d;
  logic              rsp_q, rsp_d;
  logic              retry_q, retry_d;
  logic              drained_q, drained_d;
  logic [MAX_LEN*8-1:0] payload_q;

  logic              busy;
  logic              load_en;
  logic              finish;
  logic              cap_en;
  logic [ADDR_W-1:0] chunk_addr;
  logic [OFF_W-1:0]  chunk_off;
  logic [CLEN_W-1:0] chunk_len;
  logic [LEN_W-1:0]  next_done;

  dmaseq_rst_sync u_rst_sync (
    .clk    (clk),
    .rst_n  (rst_n),
    .rst_sn (rst_sn)
  );

  dmaseq_chunk_calc #(
    .ADDR_W     (ADDR_W),
    .LINE_BYTES (LINE_BYTES),
    .MAX_LEN    (MAX_LEN)
  ) u_chunk (
    .start_addr (start_q),
    .total_len  (total_q),
    .done_len   (done_q),
    .chunk_addr (chunk_addr),
    .chunk_off  (chunk_off),
    .chunk_len  (chunk_len),
    .next_done  (next_done)
  );

  dmaseq_wr_scatter #(
    .LINE_BYTES (LINE_BYTES),
    .MAX_LEN    (MAX_LEN)
  ) u_scatter (
    .payload   (payload_q),
    .done_len  (done_q),
    .chunk_off (chunk_off),
    .chunk_len (chunk_len),
    .line_data (ds_wdata)
  );

  dmaseq_rd_gather #(
    .LINE_BYTES (LINE_BYTES),
    .MAX_LEN    (MAX_LEN)
  ) u_gather (
    .clk       (clk),
    .cap_en    (cap_en),
    .done_len  (done_q),
    .chunk_off (chunk_off),
    .chunk_len (chunk_len),
    .line_data (ds_resp_data),
    .gathered  (rsp_rdata)
  );

  assign busy       = (state_q != SQ_IDLE);
  assign req_accept = req_valid && !busy && rst_sn;
  assign req_refuse = req_valid && busy;
  assign drain_idle = drain_query && !busy;
  assign cap_en     = (state_q == SQ_WAIT) && ds_resp_valid && !write_q;

  // Next-state logic
  always_comb begin
    state_d  = state_q;
    start_d  = start_q;
    total_d  = total_q;
    done_d   = done_q;
    issued_d = issued_q;
    write_d  = write_q;
    need_d   = need_q;
    load_en  = 1'b0;
    finish   = 1'b0;

    unique case (state_q)
      SQ_IDLE: begin
        if (req_valid) begin
          load_en  = 1'b1;
          start_d  = req_addr;
          total_d  = req_len;
          done_d   = '0;
          issued_d = '0;
          write_d  = req_write;
          need_d   = req_need_rsp;
          state_d  = SQ_ISSUE;
        end
      end
      SQ_ISSUE: begin
        if (ds_ready) begin
          issued_d = next_done;
          state_d  = SQ_WAIT;
        end
      end
      SQ_WAIT: begin
        if (ds_resp_valid) begin
          done_d = issued_q;
          if (issued_q == total_q) begin
            finish  = 1'b1;
            state_d = SQ_IDLE;
          end else begin
            state_d = SQ_ISSUE;
          end
        end
      end
      default: state_d = SQ_IDLE;
    endcase

    rsp_d        = finish && need_q;
    retry_d      = finish && (retry_pend_q || req_refuse);
    retry_pend_d = finish ? 1'b0 : (retry_pend_q || req_refuse);
    drained_d    = finish && (drain_pend_q || drain_query);
    drain_pend_d = finish ? 1'b0 : (drain_pend_q || (drain_query && busy));
  end

  // Control registers
  always_ff @(posedge clk or negedge rst_sn) begin
    if (!rst_sn) begin
      state_q      <= SQ_IDLE;
      start_q      <= '0;
      total_q      <= '0;
      done_q       <= '0;
      issued_q     <= '0;
      write_q      <= 1'b0;
      need_q       <= 1'b0;
      retry_pend_q <= 1'b0;
      drain_pend_q <= 1'b0;
      rsp_q        <= 1'b0;
      retry_q      <= 1'b0;
      drained_q    <= 1'b0;
    end else begin
      state_q      <= state_d;
      start_q      <= start_d;
      total_q      <= total_d;
      done_q       <= done_d;
      issued_q     <= issued_d;
      write_q      <= write_d;
      need_q       <= need_d;
      retry_pend_q <= retry_pend_d;
      drain_pend_q <= drain_pend_d;
      rsp_q        <= rsp_d;
      retry_q      <= retry_d;
      drained_q    <= drained_d;
    end
  end

  // Payload register, loaded only on acceptance
  always_ff @(posedge clk) begin
    if (load_en) begin
      payload_q <= req_wdata;
    end
  end

  assign ds_valid     = (state_q == SQ_ISSUE);
  assign ds_store     = write_q;
  assign ds_addr      = chunk_addr;
  assign ds_line_addr = {chunk_addr[ADDR_W-1:OFF_W], {OFF_W{1'b0}}};
  assign ds_len       = chunk_len;
  assign rsp_valid    = rsp_q;
  assign rsp_write    = write_q;
  assign retry_pulse  = retry_q;
  assign drain_done   = drained_q;
endmodule

// File: rtl/dmaseq_sva.sv
module dmaseq_sva #(
  parameter int ADDR_W     = 12,
  parameter int LINE_BYTES = 8,
  parameter int MAX_LEN    = 24,
  localparam int OFF_W     = $clog2(LINE_BYTES),
  localparam int LEN_W     = $clog2(MAX_LEN + 1),
  localparam int CLEN_W    = $clog2(LINE_BYTES + 1)
) (
  input logic              clk,
  input logic              rst_n,
  input logic              busy,
  input logic [ADDR_W-1:0] start_addr,
  input logic [LEN_W-1:0]  done_len,
  input logic              req_accept,
  input logic              req_refuse,
  input logic              ds_valid,
  input logic              ds_ready,
  input logic [ADDR_W-1:0] ds_addr,
  input logic [CLEN_W-1:0] ds_len,
  input logic              rsp_valid,
  input logic              retry_pulse,
  input logic              drain_done
);
  AST_ACCEPT_ISSUES: assert property (@(posedge clk) disable iff (!rst_n)
    req_accept |=> ds_valid) else $error("accepted request did not issue"); // R3

  AST_REFUSED_NOT_STORED: assert property (@(posedge clk) disable iff (!rst_n)
    req_refuse |=> $stable(start_addr)) else $error("refused request stored"); // R1

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !ds_valid) else $error("message while idle"); // R1

  AST_FIRST_AT_START: assert property (@(posedge clk) disable iff (!rst_n)
    (ds_valid && done_len == '0) |-> ds_addr == start_addr) else $error("first piece misplaced"); // R3

  AST_PIECE_IN_LINE: assert property (@(posedge clk) disable iff (!rst_n)
    ds_valid |-> (int'(ds_addr[OFF_W-1:0]) + int'(ds_len) <= LINE_BYTES) && (ds_len != '0))
    else $error("piece crosses line"); // R3

  AST_LATER_ALIGNED: assert property (@(posedge clk) disable iff (!rst_n)
    (ds_valid && done_len != '0) |-> ds_addr[OFF_W-1:0] == '0) else $error("later piece unaligned"); // R4

  AST_STALL_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (ds_valid && !ds_ready) |=> ds_valid && $stable(ds_addr) && $stable(ds_len))
    else $error("stalled message changed"); // R6

  AST_RSP_AT_END: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> $past(busy) && !busy) else $error("completion not at end"); // R9

  AST_RSP_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |=> !rsp_valid) else $error("completion too long"); // R9

  AST_RETRY_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    retry_pulse |=> !retry_pulse) else $error("retry too long"); // R2

  AST_RETRY_AT_END: assert property (@(posedge clk) disable iff (!rst_n)
    retry_pulse |-> $past(busy) && !busy) else $error("retry not at end"); // R2

  AST_DRAINED_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    drain_done |-> $past(busy) && !busy) else $error("drained while busy"); // R10
endmodule

bind dmaseq_top dmaseq_sva #(
  .ADDR_W     (ADDR_W),
  .LINE_BYTES (LINE_BYTES),
  .MAX_LEN    (MAX_LEN)
) u_sva (
  .clk         (clk),
  .rst_n       (rst_sn),
  .busy        (busy),
  .start_addr  (start_q),
  .done_len    (done_q),
  .req_accept  (req_accept),
  .req_refuse  (req_refuse),
  .ds_valid    (ds_valid),
  .ds_ready    (ds_ready),
  .ds_addr     (ds_addr),
  .ds_len      (ds_len),
  .rsp_valid   (rsp_valid),
  .retry_pulse (retry_pulse),
  .drain_done  (drain_done)
);

// File: tb/dmaseq_top_tb.sv
module dmaseq_top_tb;
  localparam int CLK_PERIOD = 10;
  localparam int ADDR_W     = 12;
  localparam int LINE_BYTES = 8;
  localparam int MAX_LEN    = 24;
  localparam int LEN_W      = $clog2(MAX_LEN + 1);
  localparam int CLEN_W     = $clog2(LINE_BYTES + 1);

  logic clk = 1'b0;
  logic rst_n;
  logic req_valid, req_write, req_need_rsp;
  logic [ADDR_W-1:0] req_addr;
  logic [LEN_W-1:0] req_len;
  logic [MAX_LEN*8-1:0] req_wdata;
  logic req_accept, req_refuse, retry_pulse;
  logic rsp_valid, rsp_write;
  logic [MAX_LEN*8-1:0] rsp_rdata;
  logic ds_valid, ds_ready, ds_store;
  logic [ADDR_W-1:0] ds_addr, ds_line_addr;
  logic [CLEN_W-1:0] ds_len;
  logic [LINE_BYTES*8-1:0] ds_wdata;
  logic ds_resp_valid;
  logic [LINE_BYTES*8-1:0] ds_resp_data;
  logic drain_query, drain_idle, drain_done;

  dmaseq_top #(
    .ADDR_W(ADDR_W), .LINE_BYTES(LINE_BYTES), .MAX_LEN(MAX_LEN)
  ) u_dut (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_write(req_write), .req_need_rsp(req_need_rsp),
    .req_addr(req_addr), .req_len(req_len), .req_wdata(req_wdata),
    .req_accept(req_accept), .req_refuse(req_refuse), .retry_pulse(retry_pulse),
    .rsp_valid(rsp_valid), .rsp_write(rsp_write), .rsp_rdata(rsp_rdata),
    .ds_valid(ds_valid), .ds_ready(ds_ready), .ds_store(ds_store),
    .ds_addr(ds_addr), .ds_line_addr(ds_line_addr), .ds_len(ds_len),
    .ds_wdata(ds_wdata), .ds_resp_valid(ds_resp_valid), .ds_resp_data(ds_resp_data),
    .drain_query(drain_query), .drain_idle(drain_idle), .drain_done(drain_done)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int cyc = 0;
  always @(posedge clk) cyc++;

  int tests = 0;
  int fails = 0;

  // Shared state of the current transfer, seen by the downstream model
  int cur_addr, cur_len, bdone, chunk_cnt, final_cyc, resp_wait, pend_line;
  bit cur_write, xfer_done, xfer_active;
  logic [7:0] wmem [4096];

  function automatic logic [7:0] memf(int a);
    return 8'((a * 29 + 7) ^ (a >> 3));
  endfunction

  function automatic logic [7:0] wpat(int a, int i);
    return 8'(a + i * 13 + 91);
  endfunction

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic step();
    @(negedge clk);
    #1;
  endtask

  // Downstream memory model: stalls ready, delays replies, records stores
  initial begin
    ds_ready = 1'b0;
    ds_resp_valid = 1'b0;
    ds_resp_data = '0;
    resp_wait = 0;
    forever begin
      @(negedge clk);
      ds_resp_valid = 1'b0;
      ds_ready = (cyc % 3) != 0;
      if (resp_wait > 0) begin
        resp_wait--;
        if (resp_wait == 0) begin
          ds_resp_valid = 1'b1;
          for (int k = 0; k < LINE_BYTES; k++)
            ds_resp_data[k*8 +: 8] = cur_write ? 8'hA5 : memf(pend_line + k);
          if (bdone == cur_len) begin
            xfer_done = 1'b1;
            xfer_active = 1'b0;
            final_cyc = cyc;
          end
        end
      end else if (ds_valid && ds_ready && rst_n) begin
        int ea, el, rem, room;
        ea   = cur_addr + bdone;
        rem  = cur_len - bdone;
        room = LINE_BYTES - (ea % LINE_BYTES);
        el   = (rem < room) ? rem : room;
        chk(xfer_active, "R1", "message without accepted request", 1, 0);
        // R3 first piece, R4 later pieces
        chk(int'(ds_addr) == ea, (bdone == 0) ? "R3" : "R4", "piece address", ds_addr, ea);
        chk(int'(ds_len) == el, (bdone == 0) ? "R3" : "R4", "piece length", ds_len, el);
        chk(ds_store == cur_write && int'(ds_line_addr) == ea - (ea % LINE_BYTES),
            "R5", "store flag/line address", ds_line_addr, ea - (ea % LINE_BYTES));
        if (cur_write)
          for (int k = 0; k < el; k++)
            wmem[ea + k] = ds_wdata[((ea % LINE_BYTES) + k)*8 +: 8];
        bdone += el;
        chunk_cnt++;
        pend_line = ea - (ea % LINE_BYTES);
        resp_wait = 1 + (cyc % 3);
      end
    end
  end

  task automatic start_xfer(input int addr, input int len, input bit wr, input bit need);
    cur_addr = addr; cur_len = len; cur_write = wr;
    bdone = 0; chunk_cnt = 0; xfer_done = 1'b0; xfer_active = 1'b1;
    for (int i = 0; i < len; i++) wmem[addr + i] = ~wpat(addr, i);
    req_valid = 1'b1; req_write = wr; req_need_rsp = need;
    req_addr = ADDR_W'(addr); req_len = LEN_W'(len);
    for (int i = 0; i < MAX_LEN; i++)
      req_wdata[i*8 +: 8] = (i < len) ? wpat(addr, i) : 8'h00;
    #1;
    chk(req_accept == 1'b1 && req_refuse == 1'b0, "R1", "accept while idle", req_accept, 1);
    step();
    req_valid = 1'b0;
  endtask

  task automatic wait_done(input bit need, input bit exp_retry, input bit exp_drain);
    int n = 0;
    int pieces;
    int bad = 0;
    while (!xfer_done && n < 400) begin
      step();
      n++;
    end
    chk(xfer_done, "R6", "transfer completed", xfer_done, 1);
    step();
    chk(rsp_valid == need, "R9", "completion one cycle after final reply", rsp_valid, need);
    chk(cyc == final_cyc + 1, "R9", "completion cycle", cyc, final_cyc + 1);
    chk(retry_pulse == exp_retry, "R2", "retry strobe", retry_pulse, exp_retry);
    chk(drain_done == exp_drain, "R10", "drained pulse", drain_done, exp_drain);
    pieces = ((cur_addr % LINE_BYTES) + cur_len + LINE_BYTES - 1) / LINE_BYTES;
    chk(chunk_cnt == pieces, "R6", "piece count", chunk_cnt, pieces);
    if (cur_write) begin
      for (int i = 0; i < cur_len; i++)
        if (wmem[cur_addr + i] !== wpat(cur_addr, i)) bad++;
      chk(bad == 0, "R8", "stored bytes mismatching", bad, 0);
    end else if (need) begin
      chk(rsp_write == 1'b0, "R5", "completion kind", rsp_write, 0);
      for (int i = 0; i < cur_len; i++)
        if (rsp_rdata[i*8 +: 8] !== memf(cur_addr + i)) bad++;
      chk(bad == 0, "R8", "read bytes mismatching", bad, 0);
    end
  endtask

  // Watchdog
  initial begin
    repeat (150000) @(posedge clk);
    tests++;
    fails++;
    $display("FAIL R6 watchdog: actual=timeout expected=finish");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    rst_n = 1'b0;
    req_valid = 1'b0; req_write = 1'b0; req_need_rsp = 1'b0;
    req_addr = '0; req_len = '0; req_wdata = '0;
    drain_query = 1'b0;
    xfer_active = 1'b0; xfer_done = 1'b0;
    step(); step(); step();
    // Reset state
    chk(ds_valid == 1'b0, "R1", "reset ds_valid", ds_valid, 0);
    chk(rsp_valid == 1'b0 && retry_pulse == 1'b0, "R9", "reset strobes", rsp_valid, 0);
    chk(drain_done == 1'b0, "R10", "reset drained", drain_done, 0);
    rst_n = 1'b1;
    repeat (5) step();

    // R10: query while idle
    drain_query = 1'b1;
    #1;
    chk(drain_idle == 1'b1, "R10", "idle query", drain_idle, 1);
    step();
    drain_query = 1'b0;
    chk(drain_done == 1'b0, "R10", "no drained pulse when idle", drain_done, 0);

    // Sweep of offsets, lengths and directions
    for (int wr = 0; wr < 2; wr++)
      for (int off = 0; off < LINE_BYTES; off++)
        for (int len = 1; len <= MAX_LEN; len++) begin
          step();
          start_xfer(12'h200 + LINE_BYTES * (len % 5) + off, len, wr[0], 1'b1);
          wait_done(1'b1, 1'b0, 1'b0);
        end

    // R1/R2/R10/R7: refusal while busy, then immediate retry
    step();
    start_xfer(12'h305, 20, 1'b0, 1'b1);
    req_valid = 1'b1; req_write = 1'b1; req_addr = 12'h7F0; req_len = LEN_W'(3);
    drain_query = 1'b1;
    #1;
    chk(req_refuse == 1'b1 && req_accept == 1'b0, "R1", "refuse while busy", req_refuse, 1);
    chk(drain_idle == 1'b0, "R10", "busy query", drain_idle, 0);
    step();
    req_valid = 1'b0;
    drain_query = 1'b0;
    wait_done(1'b1, 1'b1, 1'b1);
    // R7: the retried request is taken in the completion cycle
    start_xfer(12'h7F3, 9, 1'b1, 1'b1);
    wait_done(1'b1, 1'b0, 1'b0);

    // R9: request without completion
    step();
    start_xfer(12'h41A, 11, 1'b1, 1'b0);
    wait_done(1'b0, 1'b0, 1'b0);
    step();
    chk(rsp_valid == 1'b0 && ds_valid == 1'b0, "R9", "silent after no-reply request", rsp_valid, 0);

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule